// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Register Group

This block holds the three registers a host reads when it services an interrupt from a SCSI bus controller: the status register (bus phase plus condition flags), the interrupt cause register and the sequence-step register. The host reaches them over a byte-wide read port with a 4-bit offset and a read strobe. Reads are combinational, so the byte is valid in the same cycle as the strobe. Read side effects take hold at the closing clock edge. The rest of the controller is represented by two inputs. One is a completion event that carries the target's status byte. The other is a phase-load strobe that records the current bus phase.

Interrupt handlers read status first, then the sequence step, and last the interrupt cause, which acknowledges the interrupt. If a completion landed partway through that walk, the host would pair a new cause with an old status. To prevent this, the block never applies a completion while an interrupt cause is still unacknowledged. The completion is parked in a one-entry slot together with its status byte. It is applied on the clock after the acknowledging read, and that raises a fresh interrupt. A second completion that arrives while the slot is full is dropped, and a sticky overrun flag records the loss.

Top module: `scsi_irqs_regs`

## Requirements
- R1: A synchronous active-high reset clears all three registers, the parked completion, the captured target status and the overrun flag, and drives `irq` low; afterwards offsets 0x4, 0x5 and 0x6 read 0x00.
- R2: Offset 0x4 reads the status register, 0x5 the interrupt cause register and 0x6 the sequence step in bits 2:0; every other offset reads 0x00.
- R3: Status bits 2:0 hold the bus phase (0 data-out, 1 data-in, 2 command, 3 status, 6 message-out, 7 message-in), loaded from `phase_in` on a cycle with `phase_load` high. Bit 4 (0x10) is terminal count. Bit 7 (0x80) reads 1 exactly when the cause register is nonzero. Bits 6, 5 and 3 read 0.
- R4: A completion that arrives with the cause register zero, no slot occupied and no cause read in that cycle takes effect at the next edge. The phase becomes 3 and terminal count sets. The sequence step becomes 0. The cause register becomes 0x10 (bus service), `irq` rises and `target_status` shows the completion's byte. With no other flags, status then reads 0x93.
- R5: A read of offset 0x5 returns the current cause value. At that edge the block clears the cause register and terminal count, sets the sequence step to 4 and drops `irq`.
- R6: A completion that arrives while the cause register is nonzero changes none of the three registers, `irq` or `target_status`; it is parked with its byte.
- R7: A parked completion is applied at the edge after the read that cleared the cause register. It then behaves as in R4, using the parked byte.
- R8: A completion that arrives while the slot is occupied and not draining in that cycle is dropped. `overrun` then goes high and stays high until reset, and the parked byte is unchanged.
- R9: When a completion and a cause read fall in the same cycle, the read is serviced first and returns the pre-existing value. The completion is applied one edge later, so `irq` reads low for exactly one cycle in between.
- R10: Reads of offsets 0x4 and 0x6 have no side effects; reading them repeatedly returns the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host register offset |
| rd_data | output | 8 | Read byte, valid in the strobe cycle |
| phase_load | input | 1 | Record `phase_in` into the status phase field |
| phase_in | input | 3 | Current bus phase code |
| cmpl_valid | input | 1 | Command-completion event, one cycle |
| cmpl_status | input | 8 | Target status byte carried by the completion |
| irq | output | 1 | Level interrupt, high while the cause register is nonzero |
| target_status | output | 8 | Target status byte of the most recently applied completion |
| overrun | output | 1 | Sticky flag: a completion was dropped |

## Verification
The completion path is tried in four arrival patterns. The first is a completion into an idle block, which must apply at once. The second arrives while an interrupt is unacknowledged and must be parked with the registers untouched. The third arrives while a completion is already parked, and must be dropped with the overrun flag raised. The fourth falls in the same cycle as the acknowledging read, and is tried both with the cause register empty and with it set; the read must win and the completion must follow one edge later. Telling parked-then-drained apart from applied-immediately rests on the one-cycle `irq` gap and on which byte appears on `target_status`. Status and sequence reads are repeated to show they do not act as an acknowledge.

// File: rtl/scsi_irqs_pkg.sv
package scsi_irqs_pkg;

    localparam int unsigned DW    = 8;
    localparam int unsigned SEQ_W = 3;

    // bus phase codes held in status bits 2:0
    typedef enum logic [2:0] {
        PH_DOUT = 3'd0,
        PH_DIN  = 3'd1,
        PH_CMD  = 3'd2,
        PH_STAT = 3'd3,
        PH_MOUT = 3'd6,
        PH_MIN  = 3'd7
    } bus_phase_e;

    // cause register bit values
    localparam logic [DW-1:0] CAUSE_FNDONE = 8'h08;
    localparam logic [DW-1:0] CAUSE_BUSSVC = 8'h10;
    localparam logic [DW-1:0] CAUSE_DISC   = 8'h20;
    localparam logic [DW-1:0] CAUSE_BUSRST = 8'h80;

    localparam logic [SEQ_W-1:0] SEQ_IDLE = 3'd0;
    localparam logic [SEQ_W-1:0] SEQ_ACKD = 3'd4;

    // architectural register state
    typedef struct packed {
        logic [DW-1:0]    cause;
        logic             tcount;
        logic [2:0]       phase;
        logic [SEQ_W-1:0] step;
        logic [DW-1:0]    tstat;
    } regs_t;

    // one-entry completion parking slot
    typedef struct packed {
        logic          full;
        logic [DW-1:0] held;
        logic          lost;
    } slot_t;

endpackage

// File: rtl/scsi_irqs_defer.sv
module scsi_irqs_defer
    import scsi_irqs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmpl_valid,
    input  logic [DW-1:0] cmpl_status,
    input  logic          cause_busy,
    input  logic          cause_rd,
    output logic          apply,
    output logic [DW-1:0] apply_status,
    output logic          lost
);

    slot_t slot_d, slot_q;
    logic  drain, direct, park;

    always_comb begin
        // parked entry drains once the cause register is empty
        drain  = slot_q.full && !cause_busy;
        // fresh completion bypasses the slot only when nothing is in the way
        direct = cmpl_valid && !cause_busy && !slot_q.full && !cause_rd;
        park   = cmpl_valid && !direct;

        slot_d = slot_q;
        if (drain) begin
            slot_d.full = 1'b0;
        end
        if (park) begin
            if (!slot_q.full || drain) begin
                slot_d.full = 1'b1;
                slot_d.held = cmpl_status;
            end else begin
                slot_d.lost = 1'b1;
            end
        end

        apply        = drain || direct;
        apply_status = drain ? slot_q.held : cmpl_status;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign lost = slot_q.lost;

    // R8: once set, the loss flag never clears without reset
    a_r8_lost_sticky: assert property (@(posedge clk) disable iff (rst)
        slot_q.lost |=> slot_q.lost);

    // R8: completion into a full, non-draining slot is dropped, held byte kept
    a_r8_drop_keeps_held: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid && slot_q.full && cause_busy)
        |=> (slot_q.lost && slot_q.held == $past(slot_q.held)));

    // R6: a completion meeting a busy cause register ends up parked
    a_r6_parked_on_busy: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid && cause_busy && !slot_q.full) |=> slot_q.full);

endmodule

// File: rtl/scsi_irqs_rdmux.sv
module scsi_irqs_rdmux
    import scsi_irqs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  regs_t             regs,
    output logic [DW-1:0]     data
);

    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] OFS_CAUSE  = ADDR_W'(4'h5);
    localparam logic [ADDR_W-1:0] OFS_STEP   = ADDR_W'(4'h6);

    logic [DW-1:0] status_byte;

    always_comb begin
        // 7: pending, 6: gross err, 5: parity err, 4: terminal count, 2:0 phase
        status_byte = {(|regs.cause), 1'b0, 1'b0, regs.tcount, 1'b0, regs.phase};
        unique case (addr)
            OFS_STATUS: data = status_byte;
            OFS_CAUSE:  data = regs.cause;
            OFS_STEP:   data = {{(DW-SEQ_W){1'b0}}, regs.step};
            default:    data = '0;
        endcase
    end

endmodule

// File: rtl/scsi_irqs_regs.sv
module scsi_irqs_regs
    import scsi_irqs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              phase_load,
    input  logic [2:0]        phase_in,
    input  logic              cmpl_valid,
    input  logic [DW-1:0]     cmpl_status,
    output logic              irq,
    output logic [DW-1:0]     target_status,
    output logic              overrun
);

    localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'(4'h5);

    regs_t         r_d, r_q;
    logic          cause_rd;
    logic          apply;
    logic [DW-1:0] apply_status;

    assign cause_rd = rd_en && (rd_addr == OFS_CAUSE);

    scsi_irqs_defer i_defer (
        .clk          (clk),
        .rst          (rst),
        .cmpl_valid   (cmpl_valid),
        .cmpl_status  (cmpl_status),
        .cause_busy   (|r_q.cause),
        .cause_rd     (cause_rd),
        .apply        (apply),
        .apply_status (apply_status),
        .lost         (overrun)
    );

    scsi_irqs_rdmux #(.ADDR_W(ADDR_W)) i_rdmux (
        .addr (rd_addr),
        .regs (r_q),
        .data (rd_data)
    );

    always_comb begin
        r_d = r_q;
        if (phase_load) begin
            r_d.phase = phase_in;
        end
        // acknowledge is serviced before any completion update
        if (cause_rd) begin
            r_d.cause  = '0;
            r_d.tcount = 1'b0;
            r_d.step   = SEQ_ACKD;
        end
        if (apply) begin
            r_d.phase  = PH_STAT;
            r_d.tcount = 1'b1;
            r_d.step   = SEQ_IDLE;
            r_d.cause  = CAUSE_BUSSVC;
            r_d.tstat  = apply_status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign irq           = |r_q.cause;
    assign target_status = r_q.tstat;

    // R1: reset leaves every register clear and the line low
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (r_q == '0 && !irq && !overrun));

    // R4: an applied completion lands as a bus-service interrupt in status phase
    a_r4_apply_loads: assert property (@(posedge clk) disable iff (rst)
        apply |=> (r_q.cause == CAUSE_BUSSVC && r_q.phase == 3'd3
                   && r_q.tcount && r_q.step == SEQ_IDLE && irq));

    // R5: an acknowledging read clears cause and terminal count, step to 4
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (cause_rd && !apply) |=> (r_q.cause == '0 && !r_q.tcount
                                  && r_q.step == SEQ_ACKD && !irq));

    // R6: nothing is applied on top of an unacknowledged cause
    a_r6_no_apply_busy: assert property (@(posedge clk) disable iff (rst)
        apply |-> (r_q.cause == '0));

    // R10: status and step reads leave all registers alone
    a_r10_quiet_reads: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cause_rd && !apply && !phase_load) |=> $stable(r_q));

endmodule

// File: tb/test_scsi_irqs_regs.sv
`timescale 1ns/100ps
module test_scsi_irqs_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       phase_load = 1'b0;
    logic [2:0] phase_in = '0;
    logic       cmpl_valid = 1'b0;
    logic [7:0] cmpl_status = '0;
    logic       irq;
    logic [7:0] target_status;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    scsi_irqs_regs i_scsi_irqs_regs (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .phase_load(phase_load), .phase_in(phase_in),
        .cmpl_valid(cmpl_valid), .cmpl_status(cmpl_status),
        .irq(irq), .target_status(target_status), .overrun(overrun)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: compare read bytes against the scoreboard, away from the edge
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 8'hff, 8'h00);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(r, rd_data, e);
            end
        end
    end

    task automatic host_rd(input logic [3:0] a, input logic [7:0] e, input string req);
        @(posedge clk); #1;
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); req_q.push_back(req);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic complete(input logic [7:0] s);
        @(posedge clk); #1;
        cmpl_valid = 1'b1; cmpl_status = s;
        @(posedge clk); #1;
        cmpl_valid = 1'b0;
    endtask

    task automatic ack_and_complete(input logic [7:0] e, input logic [7:0] s, input string req);
        @(posedge clk); #1;
        rd_en = 1'b1; rd_addr = 4'h5; cmpl_valid = 1'b1; cmpl_status = s;
        exp_q.push_back(e); req_q.push_back(req);
        @(posedge clk); #1;
        rd_en = 1'b0; cmpl_valid = 1'b0;
    endtask

    task automatic load_phase(input logic [2:0] p);
        @(posedge clk); #1;
        phase_load = 1'b1; phase_in = p;
        @(posedge clk); #1;
        phase_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, R2 offsets
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 overrun", {7'd0, overrun}, 8'h00);
        host_rd(4'h6, 8'h00, "R1 step");
        host_rd(4'h4, 8'h00, "R1 status");
        host_rd(4'h5, 8'h00, "R1 cause");
        host_rd(4'h0, 8'h00, "R2 unmapped 0x0");
        host_rd(4'hf, 8'h00, "R2 unmapped 0xf");

        // R3 phase field; R10 repeated reads are quiet
        load_phase(3'd1);
        host_rd(4'h4, 8'h01, "R3 data-in phase");
        host_rd(4'h4, 8'h01, "R10 status reread");
        host_rd(4'h6, 8'h04, "R10 step after ack");
        host_rd(4'h6, 8'h04, "R10 step reread");

        // R4 completion into idle block
        complete(8'h02);
        check("R4 irq", {7'd0, irq}, 8'h01);
        check("R4 target status", target_status, 8'h02);
        host_rd(4'h4, 8'h93, "R4 status");
        host_rd(4'h6, 8'h00, "R4 step");
        host_rd(4'h4, 8'h93, "R10 status reread");

        // R6 completion while pending is parked
        complete(8'h08);
        check("R6 target status", target_status, 8'h02);
        check("R6 irq", {7'd0, irq}, 8'h01);
        host_rd(4'h4, 8'h93, "R6 status unchanged");
        check("R6 overrun", {7'd0, overrun}, 8'h00);

        // R8 completion while slot full is dropped
        complete(8'h18);
        check("R8 overrun", {7'd0, overrun}, 8'h01);

        // R5 ack; R7 parked entry applies one edge later
        host_rd(4'h5, 8'h10, "R5 cause read");
        check("R5 irq after ack", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R7 irq re-raised", {7'd0, irq}, 8'h01);
        check("R7 parked byte", target_status, 8'h08);
        host_rd(4'h6, 8'h00, "R7 step");
        host_rd(4'h4, 8'h93, "R7 status");

        // R5 ack with nothing parked (R8 drop means no third interrupt)
        host_rd(4'h5, 8'h10, "R5 cause read");
        host_rd(4'h4, 8'h03, "R5 status after ack");
        host_rd(4'h6, 8'h04, "R5 step after ack");
        check("R5 irq", {7'd0, irq}, 8'h00);
        check("R8 sticky", {7'd0, overrun}, 8'h01);
        check("R8 dropped byte", target_status, 8'h08);

        // R9 same-cycle read and completion, cause empty
        ack_and_complete(8'h00, 8'h22, "R9 read wins (empty)");
        check("R9 irq gap", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R9 irq follows", {7'd0, irq}, 8'h01);
        check("R9 byte", target_status, 8'h22);

        // R9 same-cycle read and completion, cause set
        ack_and_complete(8'h10, 8'h33, "R9 read wins (set)");
        check("R9 irq gap", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        check("R9 irq follows", {7'd0, irq}, 8'h01);
        check("R9 byte", target_status, 8'h33);

        // R3 phase load while pending, message-out
        load_phase(3'd6);
        host_rd(4'h4, 8'h96, "R3 msg-out with pending");

        // R1 reset mid-run
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        check("R1 overrun after reset", {7'd0, overrun}, 8'h00);
        check("R1 tstat after reset", target_status, 8'h00);
        host_rd(4'h4, 8'h00, "R1 status after reset");

        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule